// File: doc/BRIEF.md
# Synchronous Serial Port Transmitter

This block serialises audio words onto a single data pin under an externally supplied bit clock and frame sync. Software, or a DMA engine, writes one word at a time into a holding register. When a frame starts, the transmitter moves the held word into its shift register and sends it most significant bit first. It then sends the remaining words of the frame back to back. Each move from the holding register raises a one-cycle data request, which tells the supplier to write the next word.

Several settings are configurable:
- word length, from 8 to 32 bits;
- number of words per frame;
- a data delay of zero or one bit clock after the frame-sync edge;
- the bit-clock edge on which data changes;
- the active level of frame sync;
- whether frame syncs that arrive in the middle of a frame are ignored.

If the holding register is empty when a word must start, the block flags an underrun and sends the previous word again in full. A 32-bit word that packs both channels of a stereo sample therefore repeats as a pair, and the channels stay in order. A frame sync that arrives while a frame is still being sent is reported as a sticky sync error. Both flags stay set until the transmitter is held in its local reset.

The whole block runs on one system clock. The bit clock and frame sync are sampled by this clock, so they must be much slower than it and already synchronised.

Top module: `sport_tx`

## Requirements
- R1: The word-length code `cfg_wlen` selects 8, 12, 16, 20, 24 or 32 bits for codes 0 to 5 (codes 6 and 7 also select 32). The low bits of the written word are sent, MSB first.
- R2: `cfg_flen` holds the number of words per frame minus one. All words of a frame are sent back to back, with no gap.
- R3: With `cfg_dly` = 0, the first data bit is driven at the bit-clock edge that samples the frame-sync start. With `cfg_dly` = 1, it is driven one bit clock later, and the pin stays low at the sync edge.
- R4: With `cfg_bclk_pol` = 1, the data pin changes only after falling edges of `ser_clk`; with 0, only after rising edges. Frame sync is sampled on that same edge.
- R5: With `cfg_fs_pol` = 1, frame sync is active low; with 0, it is active high. A frame starts on the inactive-to-active transition.
- R6: `data_req` pulses high for exactly one cycle each time the holding register is moved into the shift register.
- R7: If the holding register is empty when a word must start, `underrun` is set and the previous word is sent again in full.
- R8: A frame-sync start while a frame is in progress sets `sync_err` when `cfg_fs_ign` = 0. When `cfg_fs_ign` = 1, no flag is set. In both cases the current frame continues unchanged.
- R9: `underrun` and `sync_err` stay set until `tx_rst` is asserted. While `tx_rst` is high, both flags clear, the data pin is driven low, and any held word is discarded (a later word start underruns and sends zeros).
- R10: After `rst_n` is released, `ser_data`, `data_req`, `underrun` and `sync_err` are all 0.
- R11: The data pin is low between frames, starting from the bit-clock edge after the last bit of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_rst | input | 1 | Transmitter reset, active high; clears the error flags |
| cfg_wlen | input | 3 | Word-length code |
| cfg_flen | input | FLEN_W | Words per frame minus one |
| cfg_dly | input | 1 | Data delay: 0 or 1 bit clock |
| cfg_fs_ign | input | 1 | Ignore frame syncs that arrive mid-frame |
| cfg_bclk_pol | input | 1 | 1: drive data on falling edge; 0: drive on rising edge |
| cfg_fs_pol | input | 1 | 1: frame sync active low; 0: active high |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW | Word to transmit |
| ser_clk | input | 1 | Bit clock, synchronous to `clk` |
| frm_sync | input | 1 | Frame sync, synchronous to `clk` |
| ser_data | output | 1 | Serial data out |
| data_req | output | 1 | One-cycle pulse when the held word is consumed |
| underrun | output | 1 | Sticky underrun flag |
| sync_err | output | 1 | Sticky unexpected-frame-sync flag |

## Verification
The serial stream is compared bit by bit. The pin is sampled twice in each bit period: just before the edge that should drive it and just after. This separates a design that uses the correct edge from one that uses the opposite edge, since the latter would show the new bit one half-period early.

Frames are run with several settings:
- every word length;
- one, two and three words per frame;
- both delays;
- both clock polarities and both sync polarities.
A wrong length, a misplaced first bit or a missing idle gap each shows up as a different mismatch.

Supply patterns with fewer words than the frame needs exercise the full-word repeat. A supply of no words at all, after a transmitter reset, shows that the reset discards the held word. A spurious sync in the middle of a frame, sent with the ignore setting off and then on, must leave the stream unchanged in both runs and raise the flag only in the first.

// File: rtl/sport_tx_pkg.sv
package sport_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_e;

  // Word-length code to bit count (R1); out-of-range codes give 32 bits.
  function automatic logic [5:0] word_bits(input logic [2:0] code);
    case (code)
      3'd0:    word_bits = 6'd8;
      3'd1:    word_bits = 6'd12;
      3'd2:    word_bits = 6'd16;
      3'd3:    word_bits = 6'd20;
      3'd4:    word_bits = 6'd24;
      default: word_bits = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/sport_tx_edge.sv
module sport_tx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic frm_sync,
  input  logic bclk_pol,
  input  logic fs_pol,
  output logic drive_edge,
  output logic fs_start
);

  logic clk_d_q, clk_d_n;
  logic fs_prev_q, fs_prev_n;
  logic fs_act;

  always_comb begin
    fs_act     = frm_sync ^ fs_pol;
    drive_edge = bclk_pol ? (clk_d_q & ~ser_clk) : (~clk_d_q & ser_clk);
    fs_start   = drive_edge & fs_act & ~fs_prev_q;
    clk_d_n    = ser_clk;
    fs_prev_n  = drive_edge ? fs_act : fs_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d_q   <= 1'b0;
      fs_prev_q <= 1'b0;
    end else begin
      clk_d_q   <= clk_d_n;
      fs_prev_q <= fs_prev_n;
    end
  end

  // R4: drive edges of one direction cannot occur in adjacent cycles
  a_r4_edge_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    drive_edge |=> !drive_edge);

endmodule

// File: rtl/sport_tx_hold.sv
module sport_tx_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] word,
  output logic          data_req,
  output logic          underrun
);

  logic [DW-1:0] hold_q, hold_n;
  logic [DW-1:0] last_q, last_n;
  logic          full_q, full_n;
  logic          req_q, req_n;
  logic          urun_q, urun_n;

  always_comb begin
    hold_n = hold_q;
    last_n = last_q;
    full_n = full_q;
    urun_n = urun_q;
    req_n  = 1'b0;
    if (tx_rst) begin
      full_n = 1'b0;
      last_n = '0;
      urun_n = 1'b0;
    end else begin
      if (take) begin
        if (full_q) begin
          last_n = hold_q;
          full_n = 1'b0;
          req_n  = 1'b1;
        end else begin
          urun_n = 1'b1;
        end
      end
      if (wr_en) begin
        hold_n = wr_data;
        full_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      last_q <= '0;
      full_q <= 1'b0;
      req_q  <= 1'b0;
      urun_q <= 1'b0;
    end else begin
      hold_q <= hold_n;
      last_q <= last_n;
      full_q <= full_n;
      req_q  <= req_n;
      urun_q <= urun_n;
    end
  end

  assign word     = full_q ? hold_q : last_q;
  assign data_req = req_q;
  assign underrun = urun_q;

  // R6: request is a single-cycle pulse
  a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |=> !data_req);

  // R9: underrun flag only clears through the transmitter reset
  a_r9_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !tx_rst) |=> underrun);

  // R7: a word served from the holding register never raises underrun
  a_r7_no_urun_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> !$rose(underrun));

endmodule

// File: rtl/sport_tx_frame.sv
module sport_tx_frame
  import sport_tx_pkg::*;
#(
  parameter int DW     = 32,
  parameter int FLEN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_rst,
  input  logic              drive_edge,
  input  logic              fs_start,
  input  logic [2:0]        cfg_wlen,
  input  logic [FLEN_W-1:0] cfg_flen,
  input  logic              cfg_dly,
  input  logic              cfg_fs_ign,
  input  logic [DW-1:0]     word,
  output logic              take,
  output logic              ser_data,
  output logic              sync_err
);

  localparam int BIT_W = $clog2(DW) + 1;

  tx_state_e         st_q, st_n;
  logic [DW-1:0]     sh_q, sh_n;
  logic [BIT_W-1:0]  bc_q, bc_n;
  logic [FLEN_W-1:0] wc_q, wc_n;
  logic              chain_q, chain_n;
  logic              sd_q, sd_n;
  logic              err_q, err_n;
  logic              busy, last_e, penult, start_w, first;
  logic [5:0]        bits;
  logic [DW-1:0]     aligned;

  always_comb begin
    st_n    = st_q;
    sh_n    = sh_q;
    bc_n    = bc_q;
    wc_n    = wc_q;
    chain_n = chain_q;
    sd_n    = sd_q;
    err_n   = err_q;
    take    = 1'b0;
    start_w = 1'b0;
    first   = 1'b0;
    bits    = word_bits(cfg_wlen);
    aligned = word << (DW - int'(bits));
    busy    = (st_q != ST_IDLE);
    last_e  = (st_q == ST_SHIFT) && (bc_q == '0) && (wc_q == '0);
    penult  = (st_q == ST_SHIFT) && (bc_q == BIT_W'(1)) && (wc_q == '0);
    if (tx_rst) begin
      st_n    = ST_IDLE;
      sd_n    = 1'b0;
      chain_n = 1'b0;
      err_n   = 1'b0;
      bc_n    = '0;
      wc_n    = '0;
    end else if (drive_edge) begin
      if (fs_start && busy && !last_e && !(cfg_dly && penult) && !cfg_fs_ign)
        err_n = 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (fs_start) begin
            if (cfg_dly) st_n = ST_WAIT;
            else begin
              start_w = 1'b1;
              first   = 1'b1;
            end
          end
        end
        ST_WAIT: begin
          start_w = 1'b1;
          first   = 1'b1;
        end
        default: begin
          if (bc_q != '0) begin
            sh_n = sh_q << 1;
            sd_n = sh_q[DW-2];
            bc_n = bc_q - BIT_W'(1);
            if (fs_start && cfg_dly && penult) chain_n = 1'b1;
          end else if (wc_q != '0) begin
            start_w = 1'b1;
            wc_n    = wc_q - FLEN_W'(1);
          end else if (chain_q) begin
            chain_n = 1'b0;
            start_w = 1'b1;
            first   = 1'b1;
          end else if (fs_start && !cfg_dly) begin
            start_w = 1'b1;
            first   = 1'b1;
          end else if (fs_start) begin
            st_n = ST_WAIT;
            sd_n = 1'b0;
          end else begin
            st_n = ST_IDLE;
            sd_n = 1'b0;
          end
        end
      endcase
      if (start_w) begin
        take = 1'b1;
        sh_n = aligned;
        sd_n = aligned[DW-1];
        bc_n = BIT_W'(bits - 6'd1);
        st_n = ST_SHIFT;
        if (first) wc_n = cfg_flen;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sh_q    <= '0;
      bc_q    <= '0;
      wc_q    <= '0;
      chain_q <= 1'b0;
      sd_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      sh_q    <= sh_n;
      bc_q    <= bc_n;
      wc_q    <= wc_n;
      chain_q <= chain_n;
      sd_q    <= sd_n;
      err_q   <= err_n;
    end
  end

  assign ser_data = sd_q;
  assign sync_err = err_q;

  // R4: pin only moves after a drive edge (or a transmitter reset)
  a_r4_data_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ser_data) && !$past(tx_rst)) |-> $past(drive_edge));

  // R9: sync error is sticky until transmitter reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && !tx_rst) |=> sync_err);

  // R9: transmitter reset forces the pin low
  a_r9_rst_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> !ser_data);

  // R8: the error flag rises only on a frame-sync start
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err) |-> $past(fs_start));

endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
  parameter int DW     = 32,
  parameter int FLEN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_rst,
  input  logic [2:0]        cfg_wlen,
  input  logic [FLEN_W-1:0] cfg_flen,
  input  logic              cfg_dly,
  input  logic              cfg_fs_ign,
  input  logic              cfg_bclk_pol,
  input  logic              cfg_fs_pol,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              ser_clk,
  input  logic              frm_sync,
  output logic              ser_data,
  output logic              data_req,
  output logic              underrun,
  output logic              sync_err
);

  logic          drive_edge;
  logic          fs_start;
  logic          take;
  logic [DW-1:0] word;

  sport_tx_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk    (ser_clk),
    .frm_sync   (frm_sync),
    .bclk_pol   (cfg_bclk_pol),
    .fs_pol     (cfg_fs_pol),
    .drive_edge (drive_edge),
    .fs_start   (fs_start)
  );

  sport_tx_hold #(.DW(DW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_rst   (tx_rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .take     (take),
    .word     (word),
    .data_req (data_req),
    .underrun (underrun)
  );

  sport_tx_frame #(.DW(DW), .FLEN_W(FLEN_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_rst     (tx_rst),
    .drive_edge (drive_edge),
    .fs_start   (fs_start),
    .cfg_wlen   (cfg_wlen),
    .cfg_flen   (cfg_flen),
    .cfg_dly    (cfg_dly),
    .cfg_fs_ign (cfg_fs_ign),
    .word       (word),
    .take       (take),
    .ser_data   (ser_data),
    .sync_err   (sync_err)
  );

endmodule

// File: tb/sport_tx_bench.sv
module sport_tx_bench;
  localparam int DW     = 32;
  localparam int FLEN_W = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tx_rst;
  logic [2:0]        cfg_wlen;
  logic [FLEN_W-1:0] cfg_flen;
  logic              cfg_dly, cfg_fs_ign, cfg_bclk_pol, cfg_fs_pol;
  logic              wr_en;
  logic [DW-1:0]     wr_data;
  logic              ser_clk, frm_sync;
  logic              ser_data, data_req, underrun, sync_err;

  always #4 clk = ~clk;

  sport_tx #(.DW(DW), .FLEN_W(FLEN_W)) u_sport_tx (
    .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst),
    .cfg_wlen(cfg_wlen), .cfg_flen(cfg_flen), .cfg_dly(cfg_dly),
    .cfg_fs_ign(cfg_fs_ign), .cfg_bclk_pol(cfg_bclk_pol), .cfg_fs_pol(cfg_fs_pol),
    .wr_en(wr_en), .wr_data(wr_data), .ser_clk(ser_clk), .frm_sync(frm_sync),
    .ser_data(ser_data), .data_req(data_req), .underrun(underrun), .sync_err(sync_err)
  );

  int n_checks = 0;
  int n_errs   = 0;
  logic [DW-1:0] wq [8];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] code_of(input int bits);
    case (bits)
      8:  code_of = 3'd0;
      12: code_of = 3'd1;
      16: code_of = 3'd2;
      20: code_of = 3'd3;
      24: code_of = 3'd4;
      default: code_of = 3'd5;
    endcase
  endfunction

  // One bit period: non-drive edge, sample, then drive edge with sync, sample.
  task automatic tick(input bit fs_on, output logic pre, output logic post, output logic req);
    ser_clk = cfg_bclk_pol;
    repeat (2) @(negedge clk);
    pre = ser_data;
    frm_sync = fs_on ^ cfg_fs_pol;
    ser_clk  = ~cfg_bclk_pol;
    @(negedge clk);
    post = ser_data;
    req  = data_req;
    frm_sync = cfg_fs_pol;
  endtask

  task automatic write_word(input logic [DW-1:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tx_rst();
    @(negedge clk);
    tx_rst = 1'b1;
    repeat (2) @(negedge clk);
    check(ser_data === 1'b0, "R9", "pin during tx_rst", ser_data, 0);
    tx_rst = 1'b0;
    @(negedge clk);
    check(underrun === 1'b0 && sync_err === 1'b0, "R9", "flags after tx_rst",
          {underrun, sync_err}, 0);
  endtask

  task automatic run_frame(input string req, input int nw, input int nsup,
                           input int bits, input bit dly, input int spur);
    int total, sup, bad, reqs, exp_reqs;
    logic pre, post, rq, prev_exp, expb;
    logic [DW-1:0] w;
    int k, wi, b;
    logic [63:0] bad_act, bad_exp;
    cfg_wlen = code_of(bits);
    cfg_flen = FLEN_W'(nw - 1);
    cfg_dly  = dly;
    total = int'(dly) + nw * bits + 2;
    sup = 0; bad = 0; reqs = 0; prev_exp = 1'b0;
    bad_act = 0; bad_exp = 0;
    if (nsup > 0) begin
      write_word(wq[0]);
      sup = 1;
    end
    for (int e = 0; e < total; e++) begin
      tick(e == 0 || e == spur, pre, post, rq);
      k = e - int'(dly);
      if (k < 0 || k >= nw * bits) expb = 1'b0;
      else begin
        wi = k / bits;
        b  = bits - 1 - (k % bits);
        if (wi < nsup) w = wq[wi];
        else if (nsup > 0) w = wq[nsup-1];
        else w = '0;
        expb = w[b];
      end
      if (pre !== prev_exp || post !== expb) begin
        if (bad == 0) begin
          bad_act = {31'd0, pre, 31'd0, post} | (64'(e) << 40);
          bad_exp = {31'd0, prev_exp, 31'd0, expb} | (64'(e) << 40);
        end
        bad++;
      end
      prev_exp = expb;
      if (rq === 1'b1) begin
        reqs++;
        if (sup < nsup) begin
          write_word(wq[sup]);
          sup++;
        end
      end
    end
    check(bad == 0, req, "serial stream (edge<<40 | pre<<32 | post)", bad_act, bad_exp);
    exp_reqs = (nsup < nw) ? nsup : nw;
    check(reqs == exp_reqs, "R6", "data requests in frame", reqs, exp_reqs);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tx_rst = 1'b0; wr_en = 1'b0; wr_data = '0;
    cfg_wlen = 3'd2; cfg_flen = '0; cfg_dly = 1'b1; cfg_fs_ign = 1'b0;
    cfg_bclk_pol = 1'b1; cfg_fs_pol = 1'b0;
    ser_clk = 1'b1; frm_sync = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ser_data === 1'b0, "R10", "ser_data after reset", ser_data, 0);
    check(data_req === 1'b0 && underrun === 1'b0 && sync_err === 1'b0, "R10",
          "status after reset", {data_req, underrun, sync_err}, 0);
  endtask

  task automatic t_basic();
    cfg_bclk_pol = 1'b1; cfg_fs_pol = 1'b0;
    wq[0] = 32'h0000_A5C3; wq[1] = 32'hFFFF_3C96;
    run_frame("R1 R2 R3 R11 (16b x2, delay 1, falling edge)", 2, 2, 16, 1'b1, -1);
  endtask

  task automatic t_polarity();
    cfg_bclk_pol = 1'b0; cfg_fs_pol = 1'b1;
    wq[0] = 32'h0000_00B4; wq[1] = 32'h0000_0069; wq[2] = 32'h0000_00E1;
    run_frame("R3 R4 R5 (8b x3, delay 0, rising edge, sync low)", 3, 3, 8, 1'b0, -1);
    cfg_bclk_pol = 1'b1; cfg_fs_pol = 1'b0;
  endtask

  task automatic t_lengths();
    wq[0] = 32'hF00_0A5F;
    run_frame("R1 R2 (12b x1)", 1, 1, 12, 1'b0, -1);
    wq[0] = 32'h009_C3A7;
    run_frame("R1 (20b x1)", 1, 1, 20, 1'b1, -1);
    wq[0] = 32'h80E1_5A3C;
    run_frame("R1 (24b x1)", 1, 1, 24, 1'b0, -1);
    wq[0] = 32'hC0DE_5A17;
    run_frame("R1 (32b x1)", 1, 1, 32, 1'b1, -1);
  endtask

  task automatic t_underrun();
    wq[0] = 32'h8001_7FFE;
    run_frame("R7 (32b pair repeated)", 2, 1, 32, 1'b0, -1);
    check(underrun === 1'b1, "R7", "underrun flag", underrun, 1);
    check(sync_err === 1'b0, "R8", "no sync error on clean frame", sync_err, 0);
    wq[0] = 32'h0000_1234;
    run_frame("R9 (frame after underrun)", 1, 1, 16, 1'b1, -1);
    check(underrun === 1'b1, "R9", "underrun stays set", underrun, 1);
    pulse_tx_rst();
  endtask

  task automatic t_discard();
    write_word(32'h0000_FFFF);
    pulse_tx_rst();
    run_frame("R9 (held word discarded)", 1, 0, 16, 1'b0, -1);
    check(underrun === 1'b1, "R9", "underrun after discard", underrun, 1);
    pulse_tx_rst();
  endtask

  task automatic t_sync_err();
    cfg_fs_ign = 1'b0;
    wq[0] = 32'h0000_5AA5; wq[1] = 32'h0000_C33C;
    run_frame("R8 (mid-frame sync, flagged)", 2, 2, 16, 1'b1, 10);
    check(sync_err === 1'b1, "R8", "sync_err set", sync_err, 1);
    wq[0] = 32'h0000_0F0F;
    run_frame("R9 (frame after sync error)", 1, 1, 16, 1'b0, -1);
    check(sync_err === 1'b1, "R9", "sync_err stays set", sync_err, 1);
    pulse_tx_rst();
  endtask

  task automatic t_ignore();
    cfg_fs_ign = 1'b1;
    wq[0] = 32'h0000_96E7; wq[1] = 32'h0000_1B2D;
    run_frame("R8 (mid-frame sync, ignored)", 2, 2, 16, 1'b0, 9);
    check(sync_err === 1'b0, "R8", "sync_err with ignore", sync_err, 0);
    cfg_fs_ign = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_basic();
    t_polarity();
    t_lengths();
    t_underrun();
    t_discard();
    t_sync_err();
    t_ignore();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

endmodule